// File: doc/BRIEF.md
# Audio Receive Deserializer with Dual-Edge Microphone Mode

This block turns a serial audio data line into 32-bit received words. It follows a serial bit clock and a frame-sync line that an external master supplies. Both are sampled in the system clock domain, so the bit clock must run several times slower than `clk`. In framed mode it counts slots and bits from each frame-sync rising edge. From each slot it extracts a data word of the configured size, alignment and bit order. In the two compact modes it merges a slot pair into one word.

In dual-edge microphone mode the frame sync is ignored. One bit is taken on every bit-clock edge. Rising-edge bits belong to the left microphone and falling-edge bits to the right one. Sixteen of each fill one word.

A loop-back select takes the data from an internal transmit line instead of the pin. Each finished word goes to a holding register. A ready flag marks it unread, and a sticky overrun flag records any word that replaced an unread one. All configuration inputs are changed only while `rst` is high.

Top module: `aud_rx_deser`

## Requirements
- R1: While `rst` is high at a `clk` edge, `rx_ready`, `rx_overrun` and `rx_word` are cleared to zero from the next edge on.
- R2: Framed mode, `cfg_size`=2'b00 (32-bit), MSB first: a frame starts at a bit-clock rising edge where `fs_in` is high after being low at the previous rising edge. Slot bit 0 is taken on that edge when `cfg_delay1`=0, or on the next rising edge when `cfg_delay1`=1. The first bit received lands in bit 31 of `rx_word`.
- R3: With `cfg_lsb_first`=1, the k-th bit of a word window lands in bit k instead of bit W-1-k, where W is the word length.
- R4: With `cfg_size`=2'b01 (16-bit) and slot length S, the window is slot bits 0..15 when `cfg_slot_left`=1 and bits S-16..S-1 when it is 0. The word is right-justified in `rx_word` with zero upper bits.
- R5: With `cfg_size`=2'b10 (16-bit compact) or 2'b11 (8-bit compact), the even slot of a pair fills the low part of `rx_word` and the odd slot fills the part starting at bit 16 (16-bit) or bit 8 (8-bit). One word is produced per slot pair, and unused bits are zero.
- R6: Slot length is 8*(`cfg_slot_sel`+1) bits and the frame has `cfg_nslot_m1`+1 slots, with one word per slot in the non-compact sizes. Bit-clock edges after the last slot of a frame are ignored until the next frame start.
- R7: With `cfg_pdm2`=1, bit n (n=0..15) of a pair sequence starts on a rising edge and finishes on the following falling edge. The rising-edge bit goes to bit p and the falling-edge bit to bit 16+p, where p=n if `cfg_lsb_first`=1 and p=15-n otherwise. A word is delivered after 16 such pairs, and `fs_in` has no effect.
- R8: Each finished word sets `rx_ready` and is loaded into `rx_word`. A one-cycle `rd_strobe` clears `rx_ready`, and `rx_word` changes only when a new word arrives.
- R9: A word arriving while `rx_ready` is set sets `rx_overrun`, unless `rd_strobe` is high in that same cycle. The new word replaces the old one. `rx_overrun` stays set until `ovr_clear` is pulsed.
- R10: With `lpbk_en`=1, data bits come from `tx_sd` and `sd_in` is ignored. With `lpbk_en`=0, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial bit clock from the bus master |
| fs_in | input | 1 | Frame sync from the bus master |
| sd_in | input | 1 | Serial data pin |
| tx_sd | input | 1 | Internal transmit data line used in loop-back |
| lpbk_en | input | 1 | Select `tx_sd` as the data source |
| cfg_pdm2 | input | 1 | Dual-edge microphone mode |
| cfg_delay1 | input | 1 | One bit of delay between frame start and slot bit 0 |
| cfg_lsb_first | input | 1 | LSB-first bit order |
| cfg_slot_left | input | 1 | Word window at the start of the slot |
| cfg_size | input | 2 | 00 32-bit, 01 16-bit, 10 16-bit compact, 11 8-bit compact |
| cfg_slot_sel | input | 2 | Slot length 8*(value+1) bits |
| cfg_nslot_m1 | input | 3 | Slots per frame minus one |
| rd_strobe | input | 1 | Word read pulse, clears ready |
| ovr_clear | input | 1 | Clears the overrun flag |
| rx_word | output | 32 | Last received word |
| rx_ready | output | 1 | An unread word is held |
| rx_overrun | output | 1 | Sticky: an unread word was replaced |

## Verification
A slip in the slot or bit counters shows in the first word of the frame. The value comes out shifted, or too many or too few words appear before the next frame sync. A stuck pair counter in dual-edge mode either withholds the word entirely or merges left and right bits into the wrong half. The bench sweeps every size, slot length, alignment, bit order and delay, computing each word from the slot bits it sent. Any misplaced bit is visible within the one frame that carries it. Flag faults show as a ready flag that fails to clear, or an overrun that appears or vanishes without its cause, on the cycle after the strobe or word.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int LEN_W     = $clog2(WORD_W) + 1;
    localparam int POS_W     = $clog2(WORD_W);
    localparam int SLOT_IX_W = 3;

    typedef enum logic [1:0] {
        SZ_W32 = 2'b00,
        SZ_W16 = 2'b01,
        SZ_C16 = 2'b10,
        SZ_C8  = 2'b11
    } rx_size_e;

    // synchronized line activity, one clk cycle per event
    typedef struct packed {
        logic rise;
        logic fall;
        logic fs;
        logic sd;
    } line_evt_t;

    // one captured bit position inside the frame
    typedef struct packed {
        logic             valid;
        logic             odd;
        logic [POS_W-1:0] bit_pos;
        logic             sd;
    } slot_bit_t;

    function automatic logic [LEN_W-1:0] word_len(input rx_size_e sz);
        case (sz)
            SZ_W32:  return LEN_W'(32);
            SZ_C8:   return LEN_W'(8);
            default: return LEN_W'(16);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] slot_len(input logic [1:0] sel);
        return LEN_W'({sel, 3'b000}) + LEN_W'(8);
    endfunction

    function automatic logic is_compact(input rx_size_e sz);
        return (sz == SZ_C16) || (sz == SZ_C8);
    endfunction

    function automatic logic [LEN_W-1:0] upper_offset(input rx_size_e sz);
        case (sz)
            SZ_C16:  return LEN_W'(16);
            SZ_C8:   return LEN_W'(8);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/aud_rx_frontend.sv
module aud_rx_frontend
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_in,
    input  logic      fs_in,
    input  logic      sd_in,
    input  logic      tx_sd,
    input  logic      lpbk_en,
    output line_evt_t evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_p, fs_p, sd_p;
    logic                   sck_last;
    logic                   line_bit;

    // data source select ahead of the synchronizer
    assign line_bit = lpbk_en ? tx_sd : sd_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p    <= '0;
            fs_p     <= '0;
            sd_p     <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_p    <= {sck_p[SYNC_STAGES-2:0], sck_in};
            fs_p     <= {fs_p[SYNC_STAGES-2:0], fs_in};
            sd_p     <= {sd_p[SYNC_STAGES-2:0], line_bit};
            sck_last <= sck_p[TOP];
        end
    end

    always_comb begin
        evt.rise = sck_p[TOP] & ~sck_last;
        evt.fall = ~sck_p[TOP] & sck_last;
        evt.fs   = fs_p[TOP];
        evt.sd   = sd_p[TOP];
    end

endmodule

// File: rtl/aud_rx_frame_track.sv
module aud_rx_frame_track
    import aud_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rise,
    input  logic                 fs,
    input  logic                 sd,
    input  logic                 cfg_delay1,
    input  logic [1:0]           cfg_slot_sel,
    input  logic [SLOT_IX_W-1:0] cfg_nslot_m1,
    output slot_bit_t            cap
);
    logic                 fs_prev;
    logic                 pend;
    logic                 active;
    logic [SLOT_IX_W-1:0] slot_cnt;
    logic [POS_W-1:0]     bit_cnt;

    logic                 start;
    logic                 cur_valid;
    logic [SLOT_IX_W-1:0] cur_slot;
    logic [POS_W-1:0]     cur_bit;
    logic [LEN_W-1:0]     slen;
    logic                 slot_end;

    assign slen  = slot_len(cfg_slot_sel);
    assign start = rise & fs & ~fs_prev;

    always_comb begin
        cur_valid = 1'b0;
        cur_slot  = '0;
        cur_bit   = '0;
        if (rise) begin
            if (start) begin
                cur_valid = ~cfg_delay1;
            end else if (pend) begin
                cur_valid = 1'b1;
            end else if (active) begin
                cur_valid = 1'b1;
                cur_slot  = slot_cnt;
                cur_bit   = bit_cnt;
            end
        end
    end

    assign slot_end = ({1'b0, cur_bit} == slen - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_prev  <= 1'b0;
            pend     <= 1'b0;
            active   <= 1'b0;
            slot_cnt <= '0;
            bit_cnt  <= '0;
        end else if (rise) begin
            fs_prev <= fs;
            if (start && cfg_delay1) begin
                pend     <= 1'b1;
                active   <= 1'b0;
                slot_cnt <= '0;
                bit_cnt  <= '0;
            end else if (cur_valid) begin
                pend <= 1'b0;
                if (slot_end) begin
                    bit_cnt <= '0;
                    if (cur_slot == cfg_nslot_m1) begin
                        active   <= 1'b0;
                        slot_cnt <= '0;
                    end else begin
                        active   <= 1'b1;
                        slot_cnt <= cur_slot + SLOT_IX_W'(1);
                    end
                end else begin
                    active   <= 1'b1;
                    slot_cnt <= cur_slot;
                    bit_cnt  <= cur_bit + POS_W'(1);
                end
            end
        end
    end

    always_comb begin
        cap.valid   = cur_valid;
        cap.odd     = cur_slot[0];
        cap.bit_pos = cur_bit;
        cap.sd      = sd;
    end

endmodule

// File: rtl/aud_rx_slot_asm.sv
module aud_rx_slot_asm
    import aud_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  slot_bit_t         cap,
    input  logic              enable,
    input  logic              cfg_lsb_first,
    input  logic              cfg_slot_left,
    input  rx_size_e          cfg_size,
    input  logic [1:0]        cfg_slot_sel,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] acc, acc_n;
    logic [LEN_W-1:0]  wl, sl, fb, b6, k, idx, off;
    logic [POS_W-1:0]  pos;
    logic              in_win, cmp, first, last, capture;

    always_comb begin
        wl     = word_len(cfg_size);
        sl     = slot_len(cfg_slot_sel);
        cmp    = is_compact(cfg_size);
        fb     = (cfg_slot_left || wl >= sl) ? '0 : sl - wl;
        b6     = {1'b0, cap.bit_pos};
        in_win = (b6 >= fb) && (b6 < fb + wl);
        k      = b6 - fb;
        idx    = cfg_lsb_first ? k : (wl - LEN_W'(1) - k);
        off    = (cmp && cap.odd) ? upper_offset(cfg_size) : '0;
        pos    = POS_W'(off + idx);
        first  = (k == '0) && (!cmp || !cap.odd);
        last   = (k == wl - LEN_W'(1)) && (!cmp || cap.odd);
        capture = enable && cap.valid && in_win;

        acc_n      = first ? '0 : acc;
        acc_n[pos] = cap.sd;
    end

    always_ff @(posedge clk) begin
        if (rst)          acc <= '0;
        else if (capture) acc <= acc_n;
    end

    assign done = capture && last;
    assign word = acc_n;

endmodule

// File: rtl/aud_rx_pdm_asm.sv
module aud_rx_pdm_asm
    import aud_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         evt,
    input  logic              enable,
    input  logic              cfg_lsb_first,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(HALF_W);

    logic [WORD_W-1:0] acc, acc_n;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  pos;
    logic              got_rise;
    logic              take_l, take_r;

    always_comb begin
        pos    = cfg_lsb_first ? cnt : (CNT_W'(HALF_W - 1) - cnt);
        take_l = enable && evt.rise;
        take_r = enable && evt.fall && got_rise;
        acc_n  = acc;
        if (take_l) acc_n[pos] = evt.sd;
        if (take_r) acc_n[HALF_W + int'(pos)] = evt.sd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            cnt      <= '0;
            got_rise <= 1'b0;
        end else begin
            acc <= acc_n;
            if (take_l) begin
                got_rise <= 1'b1;
            end else if (take_r) begin
                got_rise <= 1'b0;
                cnt      <= cnt + CNT_W'(1);
            end
        end
    end

    assign done = take_r && (cnt == CNT_W'(HALF_W - 1));
    assign word = acc_n;

endmodule

// File: rtl/aud_rx_flags.sv
module aud_rx_flags
    import aud_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              rd_strobe,
    input  logic              ovr_clear,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              rx_overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word    <= '0;
            rx_ready   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (push) begin
                rx_word  <= push_word;
                rx_ready <= 1'b1;
            end else if (rd_strobe) begin
                rx_ready <= 1'b0;
            end
            if (push && rx_ready && !rd_strobe) rx_overrun <= 1'b1;
            else if (ovr_clear)                 rx_overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck_in,
    input  logic        fs_in,
    input  logic        sd_in,
    input  logic        tx_sd,
    input  logic        lpbk_en,
    input  logic        cfg_pdm2,
    input  logic        cfg_delay1,
    input  logic        cfg_lsb_first,
    input  logic        cfg_slot_left,
    input  logic [1:0]  cfg_size,
    input  logic [1:0]  cfg_slot_sel,
    input  logic [2:0]  cfg_nslot_m1,
    input  logic        rd_strobe,
    input  logic        ovr_clear,
    output logic [31:0] rx_word,
    output logic        rx_ready,
    output logic        rx_overrun
);
    line_evt_t         evt;
    slot_bit_t         cap;
    rx_size_e          size_q;
    logic              slot_done, pdm_done, push_evt;
    logic [WORD_W-1:0] slot_word, pdm_word, push_word;

    assign size_q = rx_size_e'(cfg_size);

    aud_rx_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .sck_in(sck_in), .fs_in(fs_in), .sd_in(sd_in),
        .tx_sd(tx_sd), .lpbk_en(lpbk_en), .evt(evt)
    );

    aud_rx_frame_track u_track (
        .clk(clk), .rst(rst), .rise(evt.rise), .fs(evt.fs), .sd(evt.sd),
        .cfg_delay1(cfg_delay1), .cfg_slot_sel(cfg_slot_sel),
        .cfg_nslot_m1(cfg_nslot_m1), .cap(cap)
    );

    aud_rx_slot_asm u_slot (
        .clk(clk), .rst(rst), .cap(cap), .enable(~cfg_pdm2),
        .cfg_lsb_first(cfg_lsb_first), .cfg_slot_left(cfg_slot_left),
        .cfg_size(size_q), .cfg_slot_sel(cfg_slot_sel),
        .done(slot_done), .word(slot_word)
    );

    aud_rx_pdm_asm u_pdm (
        .clk(clk), .rst(rst), .evt(evt), .enable(cfg_pdm2),
        .cfg_lsb_first(cfg_lsb_first), .done(pdm_done), .word(pdm_word)
    );

    assign push_evt  = cfg_pdm2 ? pdm_done : slot_done;
    assign push_word = cfg_pdm2 ? pdm_word : slot_word;

    aud_rx_flags u_flags (
        .clk(clk), .rst(rst), .push(push_evt), .push_word(push_word),
        .rd_strobe(rd_strobe), .ovr_clear(ovr_clear),
        .rx_word(rx_word), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
    );

endmodule

// File: rtl/aud_rx_deser_chk.sv
module aud_rx_deser_chk (
    input logic        clk,
    input logic        rst,
    input logic        push,
    input logic        slot_done,
    input logic        cfg_pdm2,
    input logic        rd_strobe,
    input logic        ovr_clear,
    input logic [31:0] rx_word,
    input logic        rx_ready,
    input logic        rx_overrun
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!rx_ready && !rx_overrun && rx_word == 32'd0));

    a_r8_ready_after_word: assert property (@(posedge clk) disable iff (rst)
        push |=> rx_ready);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !push) |=> !rx_ready);

    a_r8_word_holds: assert property (@(posedge clk) disable iff (rst)
        !push |=> $stable(rx_word));

    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (push && rx_ready && !rd_strobe) |=> rx_overrun);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !ovr_clear) |=> rx_overrun);

    a_r9_overrun_has_cause: assert property (@(posedge clk) disable iff (rst)
        (!rx_overrun && !(push && rx_ready && !rd_strobe)) |=> !rx_overrun);

    a_r7_no_framed_words: assert property (@(posedge clk) disable iff (rst)
        cfg_pdm2 |-> !slot_done);

endmodule

bind aud_rx_deser aud_rx_deser_chk u_chk (
    .clk(clk), .rst(rst), .push(push_evt), .slot_done(slot_done),
    .cfg_pdm2(cfg_pdm2), .rd_strobe(rd_strobe), .ovr_clear(ovr_clear),
    .rx_word(rx_word), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
);

// File: tb/aud_rx_deser_test.sv
module aud_rx_deser_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_in = 1'b0, fs_in = 1'b0, sd_in = 1'b0, tx_sd = 1'b0;
    logic        lpbk_en = 1'b0;
    logic        cfg_pdm2 = 1'b0, cfg_delay1 = 1'b0, cfg_lsb_first = 1'b0;
    logic        cfg_slot_left = 1'b0;
    logic [1:0]  cfg_size = 2'b00, cfg_slot_sel = 2'b11;
    logic [2:0]  cfg_nslot_m1 = 3'd0;
    logic        rd_strobe = 1'b0, ovr_clear = 1'b0;
    logic [31:0] rx_word;
    logic        rx_ready, rx_overrun;

    always #10 clk = ~clk;

    aud_rx_deser uut (
        .clk(clk), .rst(rst), .sck_in(sck_in), .fs_in(fs_in), .sd_in(sd_in),
        .tx_sd(tx_sd), .lpbk_en(lpbk_en), .cfg_pdm2(cfg_pdm2),
        .cfg_delay1(cfg_delay1), .cfg_lsb_first(cfg_lsb_first),
        .cfg_slot_left(cfg_slot_left), .cfg_size(cfg_size),
        .cfg_slot_sel(cfg_slot_sel), .cfg_nslot_m1(cfg_nslot_m1),
        .rd_strobe(rd_strobe), .ovr_clear(ovr_clear),
        .rx_word(rx_word), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
    );

    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;
    bit          auto_rd = 1'b1;
    int unsigned seed = 32'h1234_5678;
    logic [31:0] got [0:15];
    int          got_n = 0;
    logic [31:0] expv [0:15];
    int          exp_n = 0;

    function automatic logic rbit();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[16];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] ex);
        n_chk++;
        if (act !== ex) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, ex);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        finished = 1'b1;
        $finish;
    endtask

    // reader: takes each ready word and strobes a read
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && rx_ready && !rst) begin
                if (got_n < 16) got[got_n] = rx_word;
                got_n++;
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        sck_in = 1'b0;
        fs_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got_n = 0;
        exp_n = 0;
        repeat (2) @(negedge clk);
    endtask

    // the selected source carries d, the other line its inverse
    task automatic put_data(input logic d);
        sd_in = lpbk_en ? ~d : d;
        tx_sd = lpbk_en ? d : ~d;
    endtask

    task automatic send_edge(input logic fs, input logic d);
        fs_in = fs;
        put_data(d);
        repeat (2) @(negedge clk);
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
        sck_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pdm_pair(input logic l, input logic r);
        fs_in = rbit();
        put_data(l);
        repeat (2) @(negedge clk);
        sck_in = 1'b1;
        repeat (2) @(negedge clk);
        put_data(r);
        repeat (2) @(negedge clk);
        sck_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic compare_words(input string tag);
        repeat (12) @(negedge clk);
        chk({tag, " word count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 16; i++)
            chk(tag, got[i], expv[i]);
    endtask

    // one framed run, expected words computed from the slot bits sent
    task automatic run_frame(input int size, input int ssel, input bit left,
                             input bit lsb, input bit dly, input int nsl,
                             input int extra, input string tag);
        int S, W, H, fb, e;
        bit cmp;
        logic [31:0] cur;
        cfg_pdm2 = 1'b0;
        cfg_size = 2'(size);
        cfg_slot_sel = 2'(ssel);
        cfg_slot_left = left;
        cfg_lsb_first = lsb;
        cfg_delay1 = dly;
        cfg_nslot_m1 = 3'(nsl - 1);
        do_reset();
        S = (ssel + 1) * 8;
        W = (size == 0) ? 32 : (size == 3) ? 8 : 16;
        H = (size == 2) ? 16 : 8;
        cmp = (size >= 2);
        fb = (left || W >= S) ? 0 : S - W;
        cur = '0;
        send_edge(1'b0, rbit());
        send_edge(1'b0, rbit());
        e = 0;
        if (dly) begin
            send_edge(1'b1, rbit());
            e = 1;
        end
        for (int s = 0; s < nsl; s++) begin
            for (int j = 0; j < S; j++) begin
                logic b;
                b = rbit();
                send_edge(e < 2, b);
                e++;
                if (j >= fb && j < fb + W) begin
                    int k, idx, off;
                    k = j - fb;
                    idx = lsb ? k : W - 1 - k;
                    off = (cmp && (s % 2 == 1)) ? H : 0;
                    if (k == 0 && (!cmp || s % 2 == 0)) cur = '0;
                    cur[off + idx] = b;
                    if (k == W - 1 && (!cmp || s % 2 == 1)) begin
                        expv[exp_n] = cur;
                        exp_n++;
                    end
                end
            end
        end
        for (int x = 0; x < extra; x++) send_edge(1'b0, rbit());
        compare_words(tag);
    endtask

    task automatic send_word32(input logic [31:0] v);
        send_edge(1'b0, 1'b0);
        send_edge(1'b0, 1'b0);
        send_edge(1'b1, 1'b1);
        for (int j = 0; j < 32; j++) send_edge(j == 0, v[31 - j]);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1: reset values
        chk("R1 ready", {31'd0, rx_ready}, 32'd0);
        chk("R1 overrun", {31'd0, rx_overrun}, 32'd0);
        chk("R1 word", rx_word, 32'd0);

        // R2..R5 sweep of sizes, slot lengths, alignment, order, delay
        for (int size = 0; size < 4; size++)
            for (int ssel = 0; ssel < 4; ssel++) begin
                int W, S;
                string tag;
                W = (size == 0) ? 32 : (size == 3) ? 8 : 16;
                S = (ssel + 1) * 8;
                if (W <= S)
                    for (int m = 0; m < 8; m++) begin
                        if (size >= 2)      tag = "R5 compact";
                        else if (size == 1) tag = "R4 16-bit window";
                        else if (m[1])      tag = "R3 lsb first";
                        else                tag = "R2 32-bit";
                        run_frame(size, ssel, m[0], m[1], m[2], 2, 0, tag);
                    end
            end

        // R6: three slots then trailing edges ignored
        run_frame(1, 1, 1'b1, 1'b0, 1'b0, 3, 10, "R6 frame length");
        run_frame(0, 3, 1'b0, 1'b0, 1'b1, 1, 12, "R6 single slot");

        // R7: dual-edge microphone mode, both bit orders
        for (int lsb = 0; lsb < 2; lsb++) begin
            cfg_pdm2 = 1'b1;
            cfg_lsb_first = lsb[0];
            do_reset();
            for (int w = 0; w < 2; w++) begin
                logic [31:0] ex;
                ex = '0;
                for (int n = 0; n < 16; n++) begin
                    logic l, r;
                    int p;
                    l = rbit();
                    r = rbit();
                    p = lsb ? n : 15 - n;
                    ex[p] = l;
                    ex[16 + p] = r;
                    pdm_pair(l, r);
                end
                expv[exp_n] = ex;
                exp_n++;
            end
            compare_words("R7 dual edge");
        end

        // R8 / R9: flags with the reader stopped
        auto_rd = 1'b0;
        cfg_pdm2 = 1'b0;
        cfg_size = 2'b00;
        cfg_slot_sel = 2'b11;
        cfg_nslot_m1 = 3'd0;
        cfg_delay1 = 1'b1;
        cfg_lsb_first = 1'b0;
        do_reset();
        send_word32(32'hA5C3_0F96);
        chk("R8 ready set", {31'd0, rx_ready}, 32'd1);
        chk("R8 word", rx_word, 32'hA5C3_0F96);
        chk("R9 no overrun yet", {31'd0, rx_overrun}, 32'd0);
        send_word32(32'h3C1E_77D2);
        chk("R9 overrun set", {31'd0, rx_overrun}, 32'd1);
        chk("R9 word replaced", rx_word, 32'h3C1E_77D2);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        chk("R8 read clears", {31'd0, rx_ready}, 32'd0);
        chk("R8 word kept", rx_word, 32'h3C1E_77D2);
        chk("R9 sticky after read", {31'd0, rx_overrun}, 32'd1);
        ovr_clear = 1'b1;
        @(negedge clk);
        ovr_clear = 1'b0;
        @(negedge clk);
        chk("R9 cleared", {31'd0, rx_overrun}, 32'd0);
        send_word32(32'h0123_4567);
        chk("R9 no overrun when read", {31'd0, rx_overrun}, 32'd0);
        chk("R8 next word", rx_word, 32'h0123_4567);
        auto_rd = 1'b1;

        // R10: loop-back source select
        lpbk_en = 1'b1;
        do_reset();
        send_word32(32'hDEAD_BEEF);
        chk("R10 loop-back count", got_n, 1);
        chk("R10 loop-back data", got[0], 32'hDEAD_BEEF);
        lpbk_en = 1'b0;
        do_reset();
        send_word32(32'h5A5A_0FF0);
        chk("R10 pin count", got_n, 1);
        chk("R10 pin data", got[0], 32'h5A5A_0FF0);

        summary();
    end

endmodule